// File: doc/BRIEF.md
# Address-Selected Accumulator ALU

This unit is the arithmetic heart of a move-only processor. It sits in the top
sixteen words of the address space. The processor has a single instruction,
which copies one word to another address, so all computation happens as a side
effect of where a word is written. A store to one of the function addresses
combines the stored word with the accumulator, or for the shifts uses the stored
word alone, and puts the result back in the accumulator. A store to the
accumulator address loads it directly.

Reads return the accumulator, a read-only word of condition bits, or a word that
carries only the sign bit. The sign-bit word holds its bit in position 1, so
software can mask it with 2, shift it right once, and add the result to a return
address to pick one of two jump slots. Shifts move by exactly one place per
store, so a multi-place shift is a run of stores. The read path is
combinational. A store takes effect at the clock edge that samples it.

Top module: `acc_alu_window`

## Requirements
- R1: After reset the accumulator reads 0x0000 and the condition word reads 0x0001, which is only the zero bit set.
- R2: A store to 0xFE loads the accumulator with the stored word. Zero and sign are updated from it, and carry, borrow and both shift-out bits keep their values.
- R3: A store to 0xFD sets the accumulator to (acc + data) mod 2^16. Carry (bit 2) becomes the carry out of bit 15, and borrow (bit 3) is cleared.
- R4: A store to 0xFC sets the accumulator to (acc - data) mod 2^16. Borrow (bit 3) is set exactly when acc < data, unsigned, and carry is cleared.
- R5: A store to 0xFB sets the accumulator to acc AND data, and clears carry and borrow.
- R6: A store to 0xFA sets the accumulator to data >> 1. Bit 4 takes data bit 0. Carry, borrow and bit 5 are unchanged.
- R7: A store to 0xF9 sets the accumulator to data << 1. Bit 5 takes data bit 15. Carry, borrow and bit 4 are unchanged.
- R8: After every store to 0xF9 through 0xFD, zero (bit 0) is 1 exactly when the new accumulator is 0, and sign (bit 1) equals its bit 15.
- R9: A read of 0xF8 returns the condition word: bit0 zero, bit1 sign, bit2 carry, bit3 borrow, bit4 right shift-out, bit5 left shift-out, and all higher bits 0.
- R10: A read of 0xF7 returns 0x0002 when the sign bit is set and 0x0000 otherwise.
- R11: Stores to 0xF8, 0xF7, 0xFF or any other address outside 0xF9 to 0xFE change nothing. Reads of any address other than 0xF7, 0xF8 and 0xFE return 0.
- R12: While the write strobe is low, the accumulator and the condition bits hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | 8 | Word address, used for both stores and reads |
| wr_en | input | 1 | Write strobe; a store is taken at the rising edge |
| wr_data | input | 16 | Word being stored |
| rd_data | output | 16 | Combinational read result for addr |

## Verification
Some properties are checked on every cycle: a direct load, an add and a subtract give the right accumulator value, and the borrow bit agrees with the unsigned compare of the previous operands. The state does not change with the strobe low or on stores to the read-only words. The zero and sign bits agree with the accumulator, and the sign-bit word only ever reads 0 or 2. The bench scenarios cover the rest. These show which flags a given function keeps and which it clears, and that shift-out bits survive across later loads and arithmetic. They also show the full layout of the condition word, that unmapped reads return zero, and that a reset in the middle of a run restores the initial state.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

    // Offsets below the highest address of the window
    localparam int OFS_ACC  = 1;
    localparam int OFS_ADD  = 2;
    localparam int OFS_SUB  = 3;
    localparam int OFS_AND  = 4;
    localparam int OFS_SHR  = 5;
    localparam int OFS_SHL  = 6;
    localparam int OFS_FLAG = 7;
    localparam int OFS_NEG  = 8;

    localparam int FLAG_W = 6;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_LOAD,
        OP_ADD,
        OP_SUB,
        OP_AND,
        OP_SHR,
        OP_SHL
    } alu_op_e;

    // Packed MSB first: zero lands in bit 0
    typedef struct packed {
        logic lbit;
        logic rbit;
        logic uf;
        logic cy;
        logic neg;
        logic zero;
    } cond_t;

endpackage

// File: rtl/acc_alu_decode.sv
module acc_alu_decode
    import acc_alu_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    output alu_op_e           op
);
    localparam logic [ADDR_W-1:0] A_TOP = '1;
    localparam logic [ADDR_W-1:0] A_ACC = A_TOP - ADDR_W'(OFS_ACC);
    localparam logic [ADDR_W-1:0] A_ADD = A_TOP - ADDR_W'(OFS_ADD);
    localparam logic [ADDR_W-1:0] A_SUB = A_TOP - ADDR_W'(OFS_SUB);
    localparam logic [ADDR_W-1:0] A_AND = A_TOP - ADDR_W'(OFS_AND);
    localparam logic [ADDR_W-1:0] A_SHR = A_TOP - ADDR_W'(OFS_SHR);
    localparam logic [ADDR_W-1:0] A_SHL = A_TOP - ADDR_W'(OFS_SHL);

    always_comb begin
        op = OP_NONE;
        if (wr_en) begin
            unique case (addr)
                A_ACC:   op = OP_LOAD;
                A_ADD:   op = OP_ADD;
                A_SUB:   op = OP_SUB;
                A_AND:   op = OP_AND;
                A_SHR:   op = OP_SHR;
                A_SHL:   op = OP_SHL;
                default: op = OP_NONE;
            endcase
        end
    end
endmodule

// File: rtl/acc_alu_core.sv
module acc_alu_core
    import acc_alu_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  alu_op_e           op,
    input  logic [DATA_W-1:0] acc_q,
    input  cond_t             cond_q,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] acc_n,
    output cond_t             cond_n
);
    localparam int EXT_W = DATA_W + 1;

    logic [EXT_W-1:0]  sum_w;
    logic [EXT_W-1:0]  dif_w;
    logic [DATA_W-1:0] res;

    assign sum_w = {1'b0, acc_q} + {1'b0, wdata};
    assign dif_w = {1'b0, acc_q} - {1'b0, wdata};

    always_comb begin
        res    = acc_q;
        cond_n = cond_q;
        unique case (op)
            OP_LOAD: res = wdata;
            OP_ADD: begin
                res       = sum_w[DATA_W-1:0];
                cond_n.cy = sum_w[DATA_W];
                cond_n.uf = 1'b0;
            end
            OP_SUB: begin
                res       = dif_w[DATA_W-1:0];
                cond_n.uf = dif_w[DATA_W];
                cond_n.cy = 1'b0;
            end
            OP_AND: begin
                res       = acc_q & wdata;
                cond_n.cy = 1'b0;
                cond_n.uf = 1'b0;
            end
            OP_SHR: begin
                res         = wdata >> 1;
                cond_n.rbit = wdata[0];
            end
            OP_SHL: begin
                res         = wdata << 1;
                cond_n.lbit = wdata[DATA_W-1];
            end
            default: ;
        endcase
        if (op != OP_NONE) begin
            cond_n.zero = (res == '0);
            cond_n.neg  = res[DATA_W-1];
        end
        acc_n = res;
    end
endmodule

// File: rtl/acc_alu_rdmux.sv
module acc_alu_rdmux
    import acc_alu_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] acc_q,
    input  cond_t             cond_q,
    output logic [DATA_W-1:0] rd_data
);
    localparam logic [ADDR_W-1:0] A_TOP  = '1;
    localparam logic [ADDR_W-1:0] A_ACC  = A_TOP - ADDR_W'(OFS_ACC);
    localparam logic [ADDR_W-1:0] A_FLAG = A_TOP - ADDR_W'(OFS_FLAG);
    localparam logic [ADDR_W-1:0] A_NEG  = A_TOP - ADDR_W'(OFS_NEG);

    logic [DATA_W-1:0] flag_word;
    logic [DATA_W-1:0] neg_word;

    assign flag_word = {{(DATA_W-FLAG_W){1'b0}}, cond_q};
    // sign bit placed in position 1 for mask-and-shift branching
    assign neg_word  = {{(DATA_W-2){1'b0}}, cond_q.neg, 1'b0};

    always_comb begin
        unique case (addr)
            A_ACC:   rd_data = acc_q;
            A_FLAG:  rd_data = flag_word;
            A_NEG:   rd_data = neg_word;
            default: rd_data = '0;
        endcase
    end
endmodule

// File: rtl/acc_alu_window.sv
module acc_alu_window
    import acc_alu_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data
);
    localparam logic [ADDR_W-1:0] A_TOP  = '1;
    localparam logic [ADDR_W-1:0] A_ACC  = A_TOP - ADDR_W'(OFS_ACC);
    localparam logic [ADDR_W-1:0] A_ADD  = A_TOP - ADDR_W'(OFS_ADD);
    localparam logic [ADDR_W-1:0] A_SUB  = A_TOP - ADDR_W'(OFS_SUB);
    localparam logic [ADDR_W-1:0] A_FLAG = A_TOP - ADDR_W'(OFS_FLAG);
    localparam logic [ADDR_W-1:0] A_NEG  = A_TOP - ADDR_W'(OFS_NEG);

    typedef struct packed {
        logic [DATA_W-1:0] acc;
        cond_t             cond;
    } state_t;

    localparam state_t RST_STATE = '{acc: '0, cond: 6'b000001};

    state_t            st_d, st_q;
    alu_op_e           op;
    logic [DATA_W-1:0] acc_n;
    cond_t             cond_n;

    acc_alu_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr  (addr),
        .wr_en (wr_en),
        .op    (op)
    );

    acc_alu_core #(.DATA_W(DATA_W)) u_core (
        .op     (op),
        .acc_q  (st_q.acc),
        .cond_q (st_q.cond),
        .wdata  (wr_data),
        .acc_n  (acc_n),
        .cond_n (cond_n)
    );

    acc_alu_rdmux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rdmux (
        .addr    (addr),
        .acc_q   (st_q.acc),
        .cond_q  (st_q.cond),
        .rd_data (rd_data)
    );

    always_comb begin
        st_d = st_q;
        if (op != OP_NONE) begin
            st_d.acc  = acc_n;
            st_d.cond = cond_n;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RST_STATE;
        else        st_q <= st_d;
    end

    // R2: direct load lands in the accumulator
    assert_load_value_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_ACC) |=> (st_q.acc == $past(wr_data)));

    // R3: add result is the modular sum of previous accumulator and data
    assert_add_value_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_ADD) |=>
        (st_q.acc == DATA_W'($past(st_q.acc) + $past(wr_data))));

    // R4: borrow flag follows the unsigned compare of the operands
    assert_sub_borrow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_SUB) |=>
        (st_q.cond.uf == ($past(st_q.acc) < $past(wr_data))));

    // R8: zero and sign agree with the accumulator
    assert_zero_sign_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cond.zero == (st_q.acc == '0)) && (st_q.cond.neg == st_q.acc[DATA_W-1]));

    // R10: sign word only reads 0 or 2
    assert_neg_word_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == A_NEG) |-> (rd_data == DATA_W'(0) || rd_data == DATA_W'(2)));

    // R11: stores to read-only words leave state untouched
    assert_ro_store_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (addr == A_FLAG || addr == A_NEG || addr == A_TOP)) |=> $stable(st_q));

    // R12: no strobe, no change
    assert_idle_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en) |=> $stable(st_q));
endmodule

// File: tb/acc_alu_window_bench.sv
`timescale 1ns/1ps
module acc_alu_window_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  addr = 8'h00;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = 16'h0000;
    logic [15:0] rd_data;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    acc_alu_window u_acc_alu_window (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (addr),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_data (rd_data)
    );

    typedef struct packed {
        logic [7:0]  a;
        logic [15:0] d;
        logic [15:0] acc;
        logic [5:0]  fl;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 14;
    // flags: bit0 zero, bit1 sign, bit2 carry, bit3 borrow, bit4 right out, bit5 left out
    localparam vec_t VEC [NV] = '{
        '{8'hfe, 16'h0001, 16'h0001, 6'h00, 8'd2},  // R2 load
        '{8'hfc, 16'h0003, 16'hfffe, 6'h0a, 8'd4},  // R4 borrow, sign
        '{8'hfb, 16'h0002, 16'h0002, 6'h00, 8'd5},  // R5 and clears borrow
        '{8'hfd, 16'hffff, 16'h0001, 6'h04, 8'd3},  // R3 carry out
        '{8'hfa, 16'h0003, 16'h0001, 6'h14, 8'd6},  // R6 right out, carry kept
        '{8'hf9, 16'h8000, 16'h0000, 6'h35, 8'd7},  // R7 left out, zero
        '{8'hfe, 16'h8000, 16'h8000, 6'h36, 8'd2},  // R2 load keeps other bits
        '{8'hfd, 16'h8000, 16'h0000, 6'h35, 8'd3},  // R3 wrap to zero
        '{8'hfa, 16'h0002, 16'h0001, 6'h24, 8'd6},  // R6 right out cleared
        '{8'hfc, 16'h0001, 16'h0000, 6'h21, 8'd4},  // R4 equal, no borrow
        '{8'hf9, 16'h4000, 16'h8000, 6'h02, 8'd7},  // R7 sign from shift
        '{8'hf8, 16'hffff, 16'h8000, 6'h02, 8'd11}, // R11 flags word is read-only
        '{8'hf3, 16'h1234, 16'h8000, 6'h02, 8'd11}, // R11 unmapped store
        '{8'hfb, 16'h7fff, 16'h0000, 6'h01, 8'd5}   // R5 and to zero, R8
    };

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic store(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        addr    = a;
        wr_data = d;
        wr_en   = 1'b1;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic peek(input logic [7:0] a, output logic [15:0] v);
        addr = a;
        #2;
        v = rd_data;
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        peek(8'hfe, v); check("R1 acc", v, 16'h0000);
        peek(8'hf8, v); check("R1 flags", v, 16'h0001);

        for (int i = 0; i < NV; i++) begin
            string tg;
            tg = $sformatf("R%0d vec%0d", VEC[i].req, i);
            store(VEC[i].a, VEC[i].d);
            peek(8'hfe, v); check({tg, " acc"}, v, VEC[i].acc);
            peek(8'hf8, v); check({tg, " R9 flags"}, v, {10'h000, VEC[i].fl});
            peek(8'hf7, v);
            check({tg, " R10 sign word"}, v, VEC[i].fl[1] ? 16'h0002 : 16'h0000);
        end

        // R12: strobe low with an add address and data present
        @(negedge clk);
        addr = 8'hfd; wr_data = 16'h0005; wr_en = 1'b0;
        @(negedge clk);
        peek(8'hfe, v); check("R12 acc held", v, 16'h0000);
        peek(8'hf8, v); check("R12 flags held", v, 16'h0001);

        // R11: top address store ignored, unmapped reads zero
        store(8'hff, 16'h0055);
        peek(8'hfe, v); check("R11 store to top ignored", v, 16'h0000);
        peek(8'hff, v); check("R11 read top", v, 16'h0000);
        peek(8'hf0, v); check("R11 read window base", v, 16'h0000);
        store(8'hfe, 16'h1234);
        peek(8'h00, v); check("R11 read code space", v, 16'h0000);

        // R6 then R8: shift to zero sets zero and keeps carry cleared
        store(8'hfa, 16'h0001);
        peek(8'hfe, v); check("R6 shift to zero", v, 16'h0000);
        peek(8'hf8, v); check("R8 zero after shift", v, 16'h0011);

        // R1: reset in the middle of a run
        store(8'hfd, 16'hffff);
        @(negedge clk);
        rst_n = 1'b0;
        #3;
        peek(8'hfe, v); check("R1 acc after reset", v, 16'h0000);
        peek(8'hf8, v); check("R1 flags after reset", v, 16'h0001);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule